// File: doc/BRIEF.md
# Polled and Interrupting Device Controller Register Block

This block sits on a simple single-cycle register bus and fronts one slow output device. Software reaches its registers through ordinary loads and stores that fall inside a small reserved I/O window starting at the parameter `BASE`. Each register in that window has its own address. To send a word, software first places the word in the first data register. It then stores the WRITE command code into the command register. From that point the controller owns the transfer. It offers the word to the device over a valid/ready port. It then waits a fixed device latency, and on completion it reports back both through the status register and through an interrupt-pending line.

Progress is held in four named states. IDLE moves to SEND when an accepted WRITE arrives. SEND moves to WORK when the device handshake fires. WORK moves to DONE when the latency timer expires. DONE moves back to IDLE when software acknowledges. The busy and done status bits are a two-bit view of these states. Busy is set in SEND and WORK, done is set in DONE, and the combination with both bits set is never produced. A command that arrives outside IDLE is refused and recorded in the error field.

Top module: `io_dev_ctrl`

## Requirements
- R1: After reset the status word, all data registers, `irq` and `dev_valid` are zero.
- R2: The status word carries busy in bit 0, done in bit 1, an error code in bits 3:2 and interrupt-pending in bit 4. Busy and done are never both 1.
- R3: Registers sit at `BASE` plus an offset: 0 is the command register, 1 is the status register, and 2 to 5 are data registers 0 to 3. Data registers read back what was last stored. The command register reads 0. Stores outside the window change nothing, and loads outside the window return 0.
- R4: Storing code 1 (WRITE) to the command register while idle sets busy on the next cycle. `dev_valid` then rises with `dev_data` equal to data register 0 as it was at the store. Both are held until `dev_ready` is seen high on a clock edge.
- R5: Exactly `LATENCY` cycles after the handshake edge, busy drops while done and `irq` rise in the same cycle.
- R6: A command stored while busy or done is ignored, and the error code becomes 1.
- R7: A command code other than 1 stored while idle is ignored (the block stays idle), and the error code becomes 2.
- R8: A status store with bit 1 set while done clears done and `irq` and returns the block to idle. Any other status store has no effect.
- R9: An accepted WRITE clears the error code to 0.
- R10: Stores to the data registers during a transfer do not alter `dev_data` for that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Store strobe, one cycle per store |
| bus_wdata | input | DATA_W | Store data |
| bus_rdata | output | DATA_W | Load data for `bus_addr` (combinational) |
| dev_valid | output | 1 | Word offered to the device |
| dev_data | output | DATA_W | Word being offered |
| dev_ready | input | 1 | Device accepts the offered word |
| irq | output | 1 | Interrupt pending, set at completion |

## Verification
Transfers are driven with random data words and random device-ready delays, so the handshake and the fixed-latency completion are tested at varied distances from the command. Between the command and the handshake, and again while done, the stimulus randomly inserts refused commands, data-register overwrites and status stores without the acknowledge bit. This separates the refuse-and-flag path from the accept path, and shows that the captured word is independent of later stores. Directed cases then cover the reset state, bad opcodes while idle, a stray acknowledge, and addresses just below and just above the window.

// File: rtl/io_ctrl_pkg.sv
package io_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WORK = 2'd2,
        ST_DONE = 2'd3
    } ctrl_state_t;

    // register offsets from the window base
    localparam int OFF_CMD   = 0;
    localparam int OFF_STS   = 1;
    localparam int OFF_DATA0 = 2;

    // status word bit positions
    localparam int STS_BUSY   = 0;
    localparam int STS_DONE   = 1;
    localparam int STS_ERR_LO = 2;
    localparam int STS_IRQ    = 4;

    localparam int CMD_WRITE = 1;

    localparam logic [1:0] ERR_NONE   = 2'd0;
    localparam logic [1:0] ERR_BUSY   = 2'd1;
    localparam logic [1:0] ERR_OPCODE = 2'd2;

endpackage

// File: rtl/io_addr_decode.sv
module io_addr_decode #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] BASE     = 'h0300,
    parameter int                NUM_REGS = 6
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] sel
);
    logic [ADDR_W-1:0] offset;
    logic              in_window;

    assign offset    = addr - BASE;
    assign in_window = (addr >= BASE) && (offset < ADDR_W'(NUM_REGS));

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
        assign sel[i] = in_window && (offset == ADDR_W'(i));
    end
endmodule

// File: rtl/io_lat_timer.sv
module io_lat_timer #(
    parameter int LATENCY = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);
    localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;

    logic [CNT_W-1:0] cnt_q;
    logic             active_q;

    assign expired = active_q && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            cnt_q    <= CNT_W'(LATENCY - 1);
        end else if (active_q) begin
            if (cnt_q == '0) active_q <= 1'b0;
            else             cnt_q    <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/io_ctrl_fsm.sv
module io_ctrl_fsm
    import io_ctrl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic        cmd_is_write,
    input  logic        ack,
    input  logic        dev_ready,
    input  logic        tmr_expired,
    output ctrl_state_t state_q,
    output logic [1:0]  err_q,
    output logic        irq_q,
    output logic        dev_valid,
    output logic        tmr_start,
    output logic        cap_en
);
    ctrl_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_wr && cmd_is_write) state_d = ST_SEND;
            ST_SEND: if (dev_ready)              state_d = ST_WORK;
            ST_WORK: if (tmr_expired)            state_d = ST_DONE;
            ST_DONE: if (ack)                    state_d = ST_IDLE;
            default:                             state_d = ST_IDLE;
        endcase
    end

    // state register with the error and interrupt flags it governs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            err_q   <= ERR_NONE;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (cmd_wr) begin
                if (state_q != ST_IDLE) err_q <= ERR_BUSY;
                else if (!cmd_is_write) err_q <= ERR_OPCODE;
                else                    err_q <= ERR_NONE;
            end
            if (state_q == ST_WORK && tmr_expired) irq_q <= 1'b1;
            else if (state_q == ST_DONE && ack)    irq_q <= 1'b0;
        end
    end

    always_comb begin
        dev_valid = 1'b0;
        tmr_start = 1'b0;
        cap_en    = 1'b0;
        unique case (state_q)
            ST_IDLE: cap_en = cmd_wr && cmd_is_write;
            ST_SEND: begin
                dev_valid = 1'b1;
                tmr_start = dev_ready;
            end
            ST_WORK, ST_DONE: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/io_dev_ctrl.sv
module io_dev_ctrl
    import io_ctrl_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                DATA_W   = 16,
    parameter logic [ADDR_W-1:0] BASE     = 'h0300,
    parameter int                NUM_DATA = 4,
    parameter int                LATENCY  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              dev_valid,
    output logic [DATA_W-1:0] dev_data,
    input  logic              dev_ready,
    output logic              irq
);
    localparam int NUM_REGS = OFF_DATA0 + NUM_DATA;

    logic [NUM_REGS-1:0] sel;
    logic [DATA_W-1:0]   data_q [NUM_DATA];
    logic [DATA_W-1:0]   xfer_q;
    ctrl_state_t         state_q;
    logic [1:0]          err_q;
    logic                cmd_wr, ack, tmr_start, tmr_expired, cap_en;
    logic                sts_busy, sts_done;
    logic [DATA_W-1:0]   status;

    io_addr_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .NUM_REGS(NUM_REGS)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign cmd_wr = bus_wr && sel[OFF_CMD];
    assign ack    = bus_wr && sel[OFF_STS] && bus_wdata[STS_DONE];

    io_ctrl_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_wr       (cmd_wr),
        .cmd_is_write (bus_wdata == DATA_W'(CMD_WRITE)),
        .ack          (ack),
        .dev_ready    (dev_ready),
        .tmr_expired  (tmr_expired),
        .state_q      (state_q),
        .err_q        (err_q),
        .irq_q        (irq),
        .dev_valid    (dev_valid),
        .tmr_start    (tmr_start),
        .cap_en       (cap_en)
    );

    io_lat_timer #(.LATENCY(LATENCY)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .expired (tmr_expired)
    );

    for (genvar i = 0; i < NUM_DATA; i++) begin : g_data
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             data_q[i] <= '0;
            else if (bus_wr && sel[OFF_DATA0 + i])  data_q[i] <= bus_wdata;
        end
    end

    // word handed to the device is frozen when the command is accepted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      xfer_q <= '0;
        else if (cap_en) xfer_q <= data_q[0];
    end
    assign dev_data = xfer_q;

    assign sts_busy = (state_q == ST_SEND) || (state_q == ST_WORK);
    assign sts_done = (state_q == ST_DONE);

    always_comb begin
        status                          = '0;
        status[STS_BUSY]                = sts_busy;
        status[STS_DONE]                = sts_done;
        status[STS_ERR_LO +: 2]         = err_q;
        status[STS_IRQ]                 = irq;
    end

    always_comb begin
        bus_rdata = '0;
        if (sel[OFF_STS]) bus_rdata = status;
        for (int i = 0; i < NUM_DATA; i++) begin
            if (sel[OFF_DATA0 + i]) bus_rdata = data_q[i];
        end
    end
endmodule

// File: rtl/io_dev_ctrl_chk.sv
module io_dev_ctrl_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              irq,
    input logic              dev_valid,
    input logic              dev_ready,
    input logic [DATA_W-1:0] dev_data,
    input logic              cmd_wr,
    input logic              ack
);
    assert_no_reserved_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_offer_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_valid && !dev_ready) |=> (dev_valid && $stable(dev_data)));

    assert_irq_with_busy_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($fell(busy) && done));

    assert_cmd_refused_in_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && done) |=> done);

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && done) |=> (!done && !irq && !busy));
endmodule

bind io_dev_ctrl io_dev_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (sts_busy),
    .done      (sts_done),
    .irq       (irq),
    .dev_valid (dev_valid),
    .dev_ready (dev_ready),
    .dev_data  (dev_data),
    .cmd_wr    (cmd_wr),
    .ack       (ack)
);

// File: tb/io_dev_ctrl_bench.sv
module io_dev_ctrl_bench;
    localparam int          CLK_PERIOD = 10;
    localparam int          LAT        = 20;
    localparam logic [15:0] BASE       = 16'h0300;
    localparam logic [15:0] A_CMD      = BASE;
    localparam logic [15:0] A_STS      = BASE + 16'd1;
    localparam logic [15:0] A_D0       = BASE + 16'd2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        dev_valid;
    logic [15:0] dev_data;
    logic        dev_ready = 1'b0;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    io_dev_ctrl #(.BASE(BASE), .LATENCY(LAT)) u_io_dev_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_valid(dev_valid),
        .dev_data(dev_data), .dev_ready(dev_ready), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] exp_sts(input bit b, input bit d,
                                            input logic [1:0] e, input bit i);
        return {11'b0, i, e, d, b};
    endfunction

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [15:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic check_sts(input logic [15:0] exp, input string req);
        logic [15:0] v;
        bus_read(A_STS, v);
        check(v, exp, req);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog R5 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, d;
        logic [1:0]  err;
        void'($urandom(32'd4242));
        err = 2'd0;
        repeat (3) @(negedge clk);

        // R1 reset state
        check_sts(16'h0000, "R1 status");
        for (int i = 0; i < 4; i++) begin
            bus_read(A_D0 + 16'(i), v);
            check(v, 16'h0000, "R1 data");
        end
        check({15'b0, irq}, 16'd0, "R1 irq");
        check({15'b0, dev_valid}, 16'd0, "R1 dev_valid");
        rst_n = 1'b1;
        tick();

        // R3 register map and window edges
        for (int i = 0; i < 4; i++) bus_write(A_D0 + 16'(i), 16'hA000 + 16'(i));
        bus_write(BASE + 16'd6, 16'hDEAD);
        bus_write(BASE - 16'd1, 16'hBEEF);
        for (int i = 0; i < 4; i++) begin
            bus_read(A_D0 + 16'(i), v);
            check(v, 16'hA000 + 16'(i), "R3 data readback");
        end
        bus_read(BASE + 16'd6, v); check(v, 16'h0000, "R3 above window");
        bus_read(BASE - 16'd1, v); check(v, 16'h0000, "R3 below window");
        bus_read(A_CMD, v);        check(v, 16'h0000, "R3 command reads zero");

        // R8 acknowledge while idle does nothing
        bus_write(A_STS, 16'h0002);
        check_sts(16'h0000, "R8 stray ack");

        for (int t = 0; t < 16; t++) begin
            if ($urandom % 3 == 0) begin
                bus_write(A_CMD, 16'd2 + 16'($urandom % 14));
                err = 2'd2;
                check_sts(exp_sts(0, 0, err, 0), "R7 bad opcode");
                check({15'b0, dev_valid}, 16'd0, "R7 stays idle");
            end
            d = 16'($urandom);
            bus_write(A_D0, d);
            bus_write(A_CMD, 16'd1);
            err = 2'd0;
            check_sts(exp_sts(1, 0, err, 0), "R9 R4 accepted");
            check({15'b0, dev_valid}, 16'd1, "R4 valid");
            check(dev_data, d, "R4 data");
            for (int k = 0; k < int'($urandom % 4); k++) begin
                case ($urandom % 3)
                    0: tick();
                    1: bus_write(A_D0, ~d);
                    default: begin bus_write(A_CMD, 16'd1); err = 2'd1; end
                endcase
                check({15'b0, dev_valid}, 16'd1, "R4 held");
                check(dev_data, d, "R10 data frozen");
                check_sts(exp_sts(1, 0, err, 0), "R6 busy refuse");
            end
            dev_ready = 1'b1;
            tick();
            dev_ready = 1'b0;
            check({15'b0, dev_valid}, 16'd0, "R4 handshake drop");
            repeat (LAT - 1) tick();
            check_sts(exp_sts(1, 0, err, 0), "R5 still busy");
            check({15'b0, irq}, 16'd0, "R5 irq early");
            tick();
            check_sts(exp_sts(0, 1, err, 1), "R5 completion");
            check({15'b0, irq}, 16'd1, "R5 irq");
            if ($urandom % 2 == 0) begin
                bus_write(A_CMD, 16'd1);
                err = 2'd1;
                check_sts(exp_sts(0, 1, err, 1), "R6 done refuse");
                check({15'b0, dev_valid}, 16'd0, "R6 no offer");
            end
            if ($urandom % 2 == 0) begin
                bus_write(A_STS, 16'h00FD);
                check_sts(exp_sts(0, 1, err, 1), "R8 store without ack bit");
            end
            bus_write(A_STS, 16'h0002);
            check_sts(exp_sts(0, 0, err, 0), "R8 ack");
            check({15'b0, irq}, 16'd0, "R8 irq cleared");
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule